// File: doc/BRIEF.md
# ALU Status Flag Unit

This block turns the operands, result and carry-out of an 8- or 16-bit ALU operation into the six arithmetic status flags and keeps them in a register. It sits beside the ALU: each cycle where an operation is presented, it reads the operation class, the size select and the ALU's data. On the next clock edge it updates the carry, parity, nibble (auxiliary) carry, zero, sign and overflow flags. Data-transfer operations and idle cycles leave those flags as they were.

The same register also keeps three control flags: trap, interrupt enable and direction. They change only through a set/clear command input and never as a side effect of an ALU operation. Direction 0 means index registers count up, and 1 means they count down. Interrupt enable 1 lets the interrupt request input through.

Top module: `alu_flag_unit`

## Requirements
- R1: After reset is released, every bit of `flagsOut` is 0.
- R2: For an add (`opClass`=0) or a subtract (`opClass`=1) with `opValid`=1, carry (`flagsOut[0]`) takes the value of `carryOut` on the next clock edge. For a subtract, `carryOut`=1 means a borrow.
- R3: Parity (`flagsOut[1]`) is 1 when `result[7:0]` holds an even number of ones and 0 when it holds an odd number. It is updated by add, subtract and logic operations.
- R4: For add or subtract, auxiliary carry (`flagsOut[2]`) is the carry or borrow out of bit 3 into bit 4.
- R5: Zero (`flagsOut[3]`) is 1 exactly when the result is zero over the selected width. With `wideOp`=0 only `result[7:0]` counts and the upper byte is ignored.
- R6: Sign (`flagsOut[4]`) equals the result's top bit: bit 15 when `wideOp`=1 and bit 7 when `wideOp`=0.
- R7: For add or subtract, overflow (`flagsOut[5]`) is 1 when the signed result exceeds the signed range of the selected width.
- R8: A logic operation (`opClass`=2) clears carry, auxiliary carry and overflow, and it updates parity, zero and sign.
- R9: A transfer operation (`opClass`=3), or any cycle with `opValid`=0, leaves `flagsOut[5:0]` unchanged.
- R10: `ctrlCmd` sets or clears one control flag on the next edge. The codes are: 1 sets trap (`flagsOut[6]`), 2 clears it; 3 sets interrupt enable (`flagsOut[7]`), 4 clears it; 5 sets direction (`flagsOut[8]`), 6 clears it. Codes 0 and 7, and all ALU operations, leave the three control flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An ALU operation is presented this cycle |
| opClass | input | 2 | 0 add, 1 subtract, 2 logic, 3 transfer |
| wideOp | input | 1 | 1 selects 16-bit width, 0 selects 8-bit width |
| opA | input | 16 | First ALU operand |
| opB | input | 16 | Second ALU operand |
| result | input | 16 | ALU result |
| carryOut | input | 1 | ALU carry-out, or borrow for a subtract |
| ctrlCmd | input | 3 | Control flag set/clear command |
| flagsOut | output | 9 | Flag register: C, P, A, Z, S, O, T, I, D from bit 0 up |

## Verification
Directed sums at the signed and unsigned limits of both widths tell carry apart from overflow. These include 0x7F+1, 0xFF+1, 0x7FFF+1, 0x8000-1 and 0-1. Nibble-boundary values separate auxiliary carry from the full carry. Byte-mode operations with unrelated upper bytes show whether the size select truly masks zero and sign. The other cases each isolate one path:
- A logic operation after a carry shows the forced clears.
- Transfers and idle cycles after nonzero flags show the hold path.
- Each control command, issued alone and together with operations, shows the control flags.

A long run of mixed random operations is then compared cycle by cycle against a behavioural model that uses signed integer arithmetic.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int WORD_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int AUX_BIT = 4;
  localparam int NCTRL   = 3;
  localparam int FLAG_W  = 6 + NCTRL;

  // flag bit positions in the output register
  localparam int F_C = 0;
  localparam int F_P = 1;
  localparam int F_A = 2;
  localparam int F_Z = 3;
  localparam int F_S = 4;
  localparam int F_O = 5;
  localparam int F_CTRL = 6;  // trap, int-enable, direction follow

  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_SUB   = 2'd1,
    OP_LOGIC = 2'd2,
    OP_XFER  = 2'd3
  } opClass_t;

  typedef struct packed {
    logic             loadArith;
    logic             clrCarryOv;
    logic             subMode;
    logic [NCTRL-1:0] ctrlSet;
    logic [NCTRL-1:0] ctrlClr;
  } flagStrobe_t;
endpackage

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import flag_pkg::*;
(
  input  logic        opValid,
  input  logic [1:0]  opClass,
  input  logic [2:0]  ctrlCmd,
  output flagStrobe_t strb
);
  opClass_t cls;
  assign cls = opClass_t'(opClass);

  always_comb begin
    strb = '0;
    strb.loadArith  = opValid && (cls != OP_XFER);
    strb.clrCarryOv = (cls == OP_LOGIC);
    strb.subMode    = (cls == OP_SUB);
    case (ctrlCmd)
      3'd1: strb.ctrlSet[0] = 1'b1;
      3'd2: strb.ctrlClr[0] = 1'b1;
      3'd3: strb.ctrlSet[1] = 1'b1;
      3'd4: strb.ctrlClr[1] = 1'b1;
      3'd5: strb.ctrlSet[2] = 1'b1;
      3'd6: strb.ctrlClr[2] = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/flag_datapath.sv
module flag_datapath
  import flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobe_t       strb,
  input  logic              wideOp,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic [WORD_W-1:0] result,
  input  logic              carryOut,
  output logic [FLAG_W-1:0] flagsOut
);
  localparam int HI = WORD_W - 1;
  localparam int LO = BYTE_W - 1;

  logic carryQ, parQ, auxQ, zeroQ, signQ, ovQ;
  logic [NCTRL-1:0] ctrlQ;

  // per-bit carry-in pattern recovered from operands and result
  logic [WORD_W-1:0] crossVec;
  logic msbA, msbB, msbR;
  logic parNext, auxNext, zeroNext, ovNext;

  assign crossVec = opA ^ opB ^ result;
  assign msbA = wideOp ? opA[HI]    : opA[LO];
  assign msbB = wideOp ? opB[HI]    : opB[LO];
  assign msbR = wideOp ? result[HI] : result[LO];
  assign parNext  = ~^result[BYTE_W-1:0];
  assign auxNext  = crossVec[AUX_BIT];
  assign zeroNext = wideOp ? (result == '0) : (result[LO:0] == '0);
  assign ovNext   = strb.subMode ? ((msbA != msbB) && (msbR != msbA))
                                 : ((msbA == msbB) && (msbR != msbA));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      carryQ <= 1'b0;
      parQ   <= 1'b0;
      auxQ   <= 1'b0;
      zeroQ  <= 1'b0;
      signQ  <= 1'b0;
      ovQ    <= 1'b0;
    end else if (strb.loadArith) begin
      carryQ <= strb.clrCarryOv ? 1'b0 : carryOut;
      auxQ   <= strb.clrCarryOv ? 1'b0 : auxNext;
      ovQ    <= strb.clrCarryOv ? 1'b0 : ovNext;
      parQ   <= parNext;
      zeroQ  <= zeroNext;
      signQ  <= msbR;
    end
  end

  for (genvar g = 0; g < NCTRL; g++) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (!rstN)                ctrlQ[g] <= 1'b0;
      else if (strb.ctrlSet[g]) ctrlQ[g] <= 1'b1;
      else if (strb.ctrlClr[g]) ctrlQ[g] <= 1'b0;
    end

    // R10
    ctrl_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.ctrlSet[g] |=> ctrlQ[g]);
    // R10
    ctrl_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.ctrlClr[g] |=> !ctrlQ[g]);
  end

  assign flagsOut = {ctrlQ, ovQ, signQ, zeroQ, auxQ, parQ, carryQ};

  // R9
  arith_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadArith |=> $stable(flagsOut[F_O:F_C]));
  // R10
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ctrlSet == '0 && strb.ctrlClr == '0) |=> $stable(ctrlQ));
  // R8
  logic_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadArith && strb.clrCarryOv) |=> (!carryQ && !auxQ && !ovQ));
  // R5
  zero_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadArith |=> !(zeroQ && signQ));
  // R3
  parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadArith |=> (parQ == ($countones($past(result[BYTE_W-1:0])) % 2 == 0)));
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opClass,
  input  logic              wideOp,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic [WORD_W-1:0] result,
  input  logic              carryOut,
  input  logic [2:0]        ctrlCmd,
  output logic [FLAG_W-1:0] flagsOut
);
  flagStrobe_t strb;

  flag_ctrl u_ctrl (
    .opValid (opValid),
    .opClass (opClass),
    .ctrlCmd (ctrlCmd),
    .strb    (strb)
  );

  flag_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wideOp   (wideOp),
    .opA      (opA),
    .opB      (opB),
    .result   (result),
    .carryOut (carryOut),
    .flagsOut (flagsOut)
  );
endmodule

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opClass = 2'd0;
  logic        wideOp = 1'b0;
  logic [15:0] opA = '0, opB = '0, result = '0;
  logic        carryOut = 1'b0;
  logic [2:0]  ctrlCmd = 3'd0;
  logic [8:0]  flagsOut;

  int checks = 0;
  int errors = 0;
  bit expF[9];  // model: C P A Z S O T I D

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_flag_unit u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opClass(opClass),
    .wideOp(wideOp), .opA(opA), .opB(opB), .result(result),
    .carryOut(carryOut), .ctrlCmd(ctrlCmd), .flagsOut(flagsOut)
  );

  task automatic chk(string tag, string name, bit got, bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s flag %s got %0b expected %0b at %0t", tag, name, got, exp, $time);
    end
  endtask

  task automatic compareAll(int cls, bit valid, bit ctrlUsed);
    string nm[9] = '{"C","P","A","Z","S","O","T","I","D"};
    string tg[9] = '{"R2","R3","R4","R5","R6","R7","R10","R10","R10"};
    if (!valid || cls == 3) for (int i = 0; i < 6; i++) tg[i] = "R9";
    else if (cls == 2) begin tg[0] = "R8"; tg[2] = "R8"; tg[5] = "R8"; end
    for (int i = 0; i < 9; i++) chk(tg[i], nm[i], flagsOut[i], expF[i]);
    if (ctrlUsed) ;
  endtask

  // called at a negedge: drive one cycle, model the edge, check at next negedge
  task automatic step(int cls, bit wide, logic [15:0] a, logic [15:0] b, bit valid, int cmd);
    int w = wide ? 16 : 8;
    int mask = (1 << w) - 1;
    int ua = int'(a) & mask;
    int ub = int'(b) & mask;
    int r, sa, sb, sr, half;
    bit c, aux, ov;
    half = 1 << (w - 1);
    sa = (ua >= half) ? ua - (1 << w) : ua;
    sb = (ub >= half) ? ub - (1 << w) : ub;
    c = 0; aux = 0; ov = 0;
    case (cls)
      0: begin r = ua + ub; c = ((r >> w) & 1) != 0; r &= mask;
               aux = ((ua & 15) + (ub & 15)) > 15; sr = sa + sb;
               ov = (sr >= half) || (sr < -half); end
      1: begin r = (ua - ub) & mask; c = ua < ub;
               aux = (ua & 15) < (ub & 15); sr = sa - sb;
               ov = (sr >= half) || (sr < -half); end
      2: r = ua & ub;
      default: r = ua;
    endcase
    opClass  = 2'(cls);
    wideOp   = wide;
    opA      = a;
    opB      = b;
    result   = wide ? 16'(r) : {a[15:8] ^ 8'h5A, 8'(r)};
    carryOut = c;
    opValid  = valid;
    ctrlCmd  = 3'(cmd);
    if (valid && cls != 3) begin
      expF[0] = c; expF[2] = aux; expF[5] = ov;
      expF[1] = ($countones(r & 255) % 2) == 0;
      expF[3] = (r == 0);
      expF[4] = ((r >> (w - 1)) & 1) != 0;
    end
    case (cmd)
      1: expF[6] = 1; 2: expF[6] = 0;
      3: expF[7] = 1; 4: expF[7] = 0;
      5: expF[8] = 1; 6: expF[8] = 0;
      default: ;
    endcase
    @(negedge clk);
    compareAll(cls, valid, cmd != 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 9; i++) chk("R1", "reset", flagsOut[i], 1'b0);

    // R2 R4 R5 R7 byte limits
    step(0, 0, 16'hAB7F, 16'h0001, 1, 0);   // signed overflow, aux, sign
    step(0, 0, 16'h12FF, 16'h0001, 1, 0);   // carry, zero in byte despite upper bits
    step(0, 1, 16'h7FFF, 16'h0001, 1, 0);   // word overflow, R6 on bit 15
    step(1, 1, 16'h8000, 16'h0001, 1, 0);   // word sub overflow
    step(1, 0, 16'h3400, 16'h0001, 1, 0);   // borrow, aux borrow
    step(0, 0, 16'h0008, 16'h0008, 1, 0);   // nibble carry only
    step(0, 0, 16'h0003, 16'h0000, 1, 0);   // parity even
    // R8 logic after carry set
    step(1, 1, 16'h0000, 16'h0001, 1, 0);
    step(2, 1, 16'hF0F0, 16'h8F0F, 1, 0);
    // R9 hold on transfer and idle
    step(1, 0, 16'h0000, 16'h0001, 1, 0);
    step(3, 0, 16'h0000, 16'h0000, 1, 0);
    step(0, 1, 16'h0000, 16'h0000, 0, 0);
    // R10 commands
    for (int cmd = 0; cmd < 8; cmd++) step(3, 0, 16'h0001, 16'h0002, 1, cmd);
    step(0, 1, 16'hFFFF, 16'hFFFF, 1, 1);
    step(2, 0, 16'h00FF, 16'h0000, 1, 3);
    step(1, 1, 16'h1234, 16'h1234, 1, 5);
    step(0, 1, 16'h1111, 16'h2222, 1, 0);

    // mixed random operations
    for (int n = 0; n < 2000; n++)
      step($urandom_range(0, 3), 1'($urandom_range(0, 1)), 16'($urandom),
           16'($urandom), ($urandom_range(0, 7) != 0), $urandom_range(0, 7));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule